// File: doc/BRIEF.md
# Command Stream Privilege Filter

The filter walks a buffer of 32-bit command words that an unprivileged client has submitted and gives a verdict: the buffer may run as trusted, or it is refused with an error code and the word offset of the first offending word. A start pulse latches the buffer length and a flag saying whether the submitter is the privileged master client. Words then arrive one per cycle on a valid/ready handshake.

The filter tells command headers from payload words by decoding the length of each command. Only the opcodes that need policing sit in a 16-entry rule table. Every other command is stepped over using the standard length of its opcode class. A rule can override that length, refuse the command outright, limit it to the master client, or treat it as a register-load whose offset words must appear in a 16-entry register whitelist. Any rule can also carry a mask/value test on one chosen word of the command. This test is how commands that point at privileged memory, such as the global translation table or the hardware status page, are refused for every client. Both tables are loaded through a write port that is open only while no scan is running.

Top module: `cspf_filter`

## Requirements
- R1: A header whose opcode (bits [31:24]) has no valid rule is stepped over using its class, bits [31:29]. Class 0 is 1 word long. Any other class is bits [7:0] plus 2 words long. Payload words are never decoded as headers.
- R2: A rule with a nonzero length field sets the command length to that value, in place of the class length. A skip rule (category 0) accepts the command.
- R3: A header that matches a deny rule (category 1) ends the scan with error code 1 at the header's offset.
- R4: A header that matches a master-only rule (category 2) ends the scan with error code 2 at the header's offset when the latched master flag is clear. The command passes when the flag is set.
- R5: For a register-load rule (category 3), each word at an odd index inside the command (1, 3, 5, ...) is a register offset. It must equal an entry of the whitelist, or the scan ends with error code 3 at that word's offset. Words at even indices are not checked. The master flag makes no difference.
- R6: A rule with its check enable set compares one word of the command: the word at the check index, where 0 is the header, ANDed with the mask. If the result differs from the expected value, the scan ends with error code 4 at that word's offset. The master flag makes no difference.
- R7: A header with opcode 0x05 ends the scan accepted: accept is 1, the error code is 0 and the offset is that of the end word.
- R8: If the scan reaches the latched buffer length without an end command, it ends with error code 5 and an offset equal to the buffer length. This includes a command that runs past the end of the buffer, and a length of zero.
- R9: Once a verdict is given, done stays high, wordReady stays low and no further words are consumed. The verdict outputs hold until the next start pulse.
- R10: Writes to the rule table or the whitelist while a scan is running have no effect.
- R11: A word is consumed only in a cycle in which wordValid and wordReady are both high. Gaps in wordValid do not change the verdict.
- R12: After reset, busy, done, wordReady, accept and errCode are all 0, and both tables hold no valid entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan when no scan is running |
| isMaster | input | 1 | Submitter is the master client; latched at start |
| bufLen | input | POS_W | Buffer length in words; latched at start |
| wordValid | input | 1 | wordData holds a valid word |
| wordData | input | 32 | Command word at the current offset |
| wordReady | output | 1 | Filter takes a word this cycle |
| cfgRuleWe | input | 1 | Write one rule entry |
| cfgWlWe | input | 1 | Write one whitelist entry |
| cfgIdx | input | IDX_W | Entry index for either write |
| cfgValid | input | 1 | Valid bit for the written entry |
| cfgOp | input | 8 | Rule opcode, matched against header bits [31:24] |
| cfgCat | input | 2 | Rule category: 0 skip, 1 deny, 2 master-only, 3 register-load |
| cfgLen | input | 8 | Rule length override; 0 keeps the class length |
| cfgChkEn | input | 1 | Rule mask check enable |
| cfgChkIdx | input | 8 | Index of the word the mask check tests |
| cfgMask | input | 32 | Mask check mask |
| cfgValue | input | 32 | Mask check expected value |
| cfgWlAddr | input | 32 | Whitelisted register offset |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Verdict available |
| accept | output | 1 | Buffer accepted |
| errCode | output | 3 | 0 none, 1 denied, 2 master-only, 3 register, 4 mask, 5 overrun |
| errOffset | output | POS_W | Offset of the offending or end word |

## Verification
Buffers mix unlisted commands of several classes whose payloads look like forbidden headers. Only correct length decoding accepts them, so the skip override and the class lengths are tested apart from the rule lookup. Register-load buffers place a bad value in an even slot and a bad offset in an odd slot, which shows whether the whitelist is applied to the right words. Both are run with the master flag set and clear. Overrun is tried with a buffer that simply runs out, a command whose length crosses the end, and a zero length. A gapped-valid run and a table write made during a stalled scan show that the verdict depends only on the words and on the tables as they were at start.

// File: rtl/cspf_pkg.sv
package cspf_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 8;
  localparam int LEN_W  = 8;

  typedef enum logic [1:0] {
    CAT_SKIP   = 2'd0,
    CAT_DENY   = 2'd1,
    CAT_MASTER = 2'd2,
    CAT_REG    = 2'd3
  } ruleCat_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_DENIED     = 3'd1,
    ERR_NOT_MASTER = 3'd2,
    ERR_REG        = 3'd3,
    ERR_MASK       = 3'd4,
    ERR_OVERRUN    = 3'd5
  } errCode_e;

  // action part of a rule (opcode and valid are held apart for matching)
  typedef struct packed {
    ruleCat_e          cat;
    logic [LEN_W-1:0]  len;
    logic              chkEn;
    logic [LEN_W-1:0]  chkIdx;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] value;
  } ruleAct_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic step;
    logic cfgOpen;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic     atEnd;
    logic     isEnd;
    logic     fault;
    errCode_e code;
  } dpSts_t;
endpackage

// File: rtl/cspf_rules.sv
module cspf_rules
  import cspf_pkg::*;
#(
  parameter int RULES = 16,
  parameter int WL    = 16,
  localparam int RIDX_W = $clog2(RULES),
  localparam int WIDX_W = $clog2(WL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ruleWe,
  input  logic              wlWe,
  input  logic [RIDX_W-1:0] ruleIdx,
  input  logic [WIDX_W-1:0] wlIdx,
  input  logic              validIn,
  input  logic [OP_W-1:0]   opIn,
  input  ruleAct_t          actIn,
  input  logic [WORD_W-1:0] wlAddrIn,
  input  logic [OP_W-1:0]   lookupOp,
  input  logic [WORD_W-1:0] lookupReg,
  input  logic [RIDX_W-1:0] readIdx,
  output logic              hit,
  output logic [RIDX_W-1:0] hitIdx,
  output ruleAct_t          hitAct,
  output ruleAct_t          selAct,
  output logic              wlHit
);
  logic [RULES-1:0] ruleValid;
  logic [OP_W-1:0]  ruleOp  [RULES];
  ruleAct_t         ruleAct [RULES];
  logic [WL-1:0]    wlValid;
  logic [WORD_W-1:0] wlAddr [WL];
  logic [RULES-1:0] opMatch;
  logic [WL-1:0]    wlMatch;

  for (genvar g = 0; g < RULES; g++) begin : gRule
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ruleValid[g] <= 1'b0;
        ruleOp[g]    <= '0;
        ruleAct[g]   <= '0;
      end else if (ruleWe && ruleIdx == RIDX_W'(g)) begin
        ruleValid[g] <= validIn;
        ruleOp[g]    <= opIn;
        ruleAct[g]   <= actIn;
      end
    end
    assign opMatch[g] = ruleValid[g] && (ruleOp[g] == lookupOp);
  end

  for (genvar g = 0; g < WL; g++) begin : gWl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wlValid[g] <= 1'b0;
        wlAddr[g]  <= '0;
      end else if (wlWe && wlIdx == WIDX_W'(g)) begin
        wlValid[g] <= validIn;
        wlAddr[g]  <= wlAddrIn;
      end
    end
    assign wlMatch[g] = wlValid[g] && (wlAddr[g] == lookupReg);
  end

  // lowest matching index wins
  always_comb begin
    hitIdx = '0;
    for (int i = RULES - 1; i >= 0; i--) begin
      if (opMatch[i]) hitIdx = RIDX_W'(i);
    end
  end

  assign hit    = |opMatch;
  assign hitAct = ruleAct[hitIdx];
  assign selAct = ruleAct[readIdx];
  assign wlHit  = |wlMatch;
endmodule

// File: rtl/cspf_datapath.sv
module cspf_datapath
  import cspf_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int RULES  = 16,
  parameter int WL     = 16,
  parameter logic [OP_W-1:0] END_OP = 8'h05,
  localparam int RIDX_W = $clog2(RULES),
  localparam int WIDX_W = $clog2(WL),
  localparam int CNT_W  = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              isMaster,
  input  logic [POS_W-1:0]  bufLen,
  input  logic [WORD_W-1:0] word,
  input  logic              cfgRuleWe,
  input  logic              cfgWlWe,
  input  logic [RIDX_W-1:0] cfgIdx,
  input  logic              cfgValid,
  input  logic [OP_W-1:0]   cfgOp,
  input  ruleAct_t          cfgAct,
  input  logic [WORD_W-1:0] cfgWlAddr,
  output dpSts_t            sts,
  output logic [POS_W-1:0]  pos
);
  logic [POS_W-1:0]  lenQ;
  logic              masterQ;
  logic              inBody;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  wordIdx;
  logic [RIDX_W-1:0] curIdx;
  logic              curHit;

  logic              hit, wlHit;
  logic [RIDX_W-1:0] hitIdx;
  ruleAct_t          hitAct, selAct, act;
  logic              actHit;
  logic [CNT_W-1:0]  stdLen, cmdLen, curWordIdx;
  logic              maskBad;

  cspf_rules #(.RULES(RULES), .WL(WL)) u_rules (
    .clk      (clk),
    .rstN     (rstN),
    .ruleWe   (cfgRuleWe && ctl.cfgOpen),
    .wlWe     (cfgWlWe && ctl.cfgOpen),
    .ruleIdx  (cfgIdx),
    .wlIdx    (WIDX_W'(cfgIdx)),
    .validIn  (cfgValid),
    .opIn     (cfgOp),
    .actIn    (cfgAct),
    .wlAddrIn (cfgWlAddr),
    .lookupOp (word[WORD_W-1 -: OP_W]),
    .lookupReg(word),
    .readIdx  (curIdx),
    .hit      (hit),
    .hitIdx   (hitIdx),
    .hitAct   (hitAct),
    .selAct   (selAct),
    .wlHit    (wlHit)
  );

  // header-phase decoding uses the matching rule, body phase the latched one
  assign act        = inBody ? selAct : hitAct;
  assign actHit     = inBody ? curHit : hit;
  assign curWordIdx = inBody ? wordIdx : '0;
  assign stdLen     = (word[31:29] == 3'd0) ? CNT_W'(1) : CNT_W'(word[LEN_W-1:0]) + CNT_W'(2);
  assign cmdLen     = (actHit && act.len != '0) ? CNT_W'(act.len) : stdLen;
  assign maskBad    = actHit && act.chkEn && (CNT_W'(act.chkIdx) == curWordIdx)
                      && ((word & act.mask) != act.value);

  always_comb begin
    sts.atEnd = (pos == lenQ);
    sts.isEnd = !inBody && (word[WORD_W-1 -: OP_W] == END_OP);
    sts.fault = 1'b0;
    sts.code  = ERR_NONE;
    if (!inBody) begin
      if (sts.isEnd) begin
        sts.code = ERR_NONE;
      end else if (hit && act.cat == CAT_DENY) begin
        sts.fault = 1'b1;
        sts.code  = ERR_DENIED;
      end else if (hit && act.cat == CAT_MASTER && !masterQ) begin
        sts.fault = 1'b1;
        sts.code  = ERR_NOT_MASTER;
      end else if (maskBad) begin
        sts.fault = 1'b1;
        sts.code  = ERR_MASK;
      end
    end else begin
      if (curHit && act.cat == CAT_REG && wordIdx[0] && !wlHit) begin
        sts.fault = 1'b1;
        sts.code  = ERR_REG;
      end else if (maskBad) begin
        sts.fault = 1'b1;
        sts.code  = ERR_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      lenQ    <= '0;
      masterQ <= 1'b0;
      inBody  <= 1'b0;
      remain  <= '0;
      wordIdx <= '0;
      curIdx  <= '0;
      curHit  <= 1'b0;
    end else if (ctl.clear) begin
      pos     <= '0;
      lenQ    <= bufLen;
      masterQ <= isMaster;
      inBody  <= 1'b0;
      remain  <= '0;
      wordIdx <= '0;
      curHit  <= 1'b0;
    end else if (ctl.step) begin
      pos <= pos + POS_W'(1);
      if (!inBody) begin
        if (cmdLen > CNT_W'(1)) begin
          inBody  <= 1'b1;
          remain  <= cmdLen - CNT_W'(1);
          wordIdx <= CNT_W'(1);
          curIdx  <= hitIdx;
          curHit  <= hit;
        end
      end else begin
        wordIdx <= wordIdx + CNT_W'(1);
        remain  <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) inBody <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cspf_ctrl.sv
module cspf_ctrl
  import cspf_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             wordValid,
  input  dpSts_t           sts,
  input  logic [POS_W-1:0] pos,
  output dpCtl_t           ctl,
  output logic             wordReady,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [2:0]       errCode,
  output logic [POS_W-1:0] errOffset
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
  state_e state;

  assign busy        = (state == ST_RUN);
  assign done        = (state == ST_FIN);
  assign wordReady   = busy && !sts.atEnd;
  assign ctl.clear   = start && !busy;
  assign ctl.step    = wordReady && wordValid && !sts.fault && !sts.isEnd;
  assign ctl.cfgOpen = !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      accept    <= 1'b0;
      errCode   <= ERR_NONE;
      errOffset <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (sts.atEnd) begin
            state     <= ST_FIN;
            errCode   <= ERR_OVERRUN;
            errOffset <= pos;
          end else if (wordValid && sts.fault) begin
            state     <= ST_FIN;
            errCode   <= sts.code;
            errOffset <= pos;
          end else if (wordValid && sts.isEnd) begin
            state     <= ST_FIN;
            accept    <= 1'b1;
            errOffset <= pos;
          end
        end
        default: begin
          if (start) begin
            state     <= ST_RUN;
            accept    <= 1'b0;
            errCode   <= ERR_NONE;
            errOffset <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cspf_filter.sv
module cspf_filter
  import cspf_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int RULES = 16,
  parameter int WL    = 16,
  parameter logic [7:0] END_OP = 8'h05,
  localparam int IDX_W = $clog2(RULES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isMaster,
  input  logic [POS_W-1:0] bufLen,
  input  logic             wordValid,
  input  logic [31:0]      wordData,
  output logic             wordReady,
  input  logic             cfgRuleWe,
  input  logic             cfgWlWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgValid,
  input  logic [7:0]       cfgOp,
  input  logic [1:0]       cfgCat,
  input  logic [7:0]       cfgLen,
  input  logic             cfgChkEn,
  input  logic [7:0]       cfgChkIdx,
  input  logic [31:0]      cfgMask,
  input  logic [31:0]      cfgValue,
  input  logic [31:0]      cfgWlAddr,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [2:0]       errCode,
  output logic [POS_W-1:0] errOffset
);
  dpCtl_t           ctl;
  dpSts_t           sts;
  logic [POS_W-1:0] pos;
  ruleAct_t         cfgAct;

  assign cfgAct = '{cat: ruleCat_e'(cfgCat), len: cfgLen, chkEn: cfgChkEn,
                    chkIdx: cfgChkIdx, mask: cfgMask, value: cfgValue};

  cspf_datapath #(.POS_W(POS_W), .RULES(RULES), .WL(WL), .END_OP(END_OP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .isMaster (isMaster),
    .bufLen   (bufLen),
    .word     (wordData),
    .cfgRuleWe(cfgRuleWe),
    .cfgWlWe  (cfgWlWe),
    .cfgIdx   (cfgIdx),
    .cfgValid (cfgValid),
    .cfgOp    (cfgOp),
    .cfgAct   (cfgAct),
    .cfgWlAddr(cfgWlAddr),
    .sts      (sts),
    .pos      (pos)
  );

  cspf_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wordValid(wordValid),
    .sts      (sts),
    .pos      (pos),
    .ctl      (ctl),
    .wordReady(wordReady),
    .busy     (busy),
    .done     (done),
    .accept   (accept),
    .errCode  (errCode),
    .errOffset(errOffset)
  );
endmodule

// File: rtl/cspf_filter_checks.sv
module cspf_filter_checks #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             wordReady,
  input logic             busy,
  input logic             done,
  input logic             accept,
  input logic [2:0]       errCode,
  input logic [POS_W-1:0] errOffset
);
  // R9: a verdict holds until the next start
  a_r9_hold_verdict: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(accept) && $stable(errCode) && $stable(errOffset));

  // R9: no word is taken once a verdict is out
  a_r9_no_ready_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wordReady);

  // R7: accept goes with error code 0 and only with it
  a_r7_accept_code: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (accept == (errCode == 3'd0)));

  // R11: words are taken only during a scan
  a_r11_ready_busy: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> busy && !done);

  // R8: a running scan that stops taking words has hit the buffer end
  a_r8_end_verdict: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wordReady |=> done && !accept && errCode == 3'd5);
endmodule

bind cspf_filter cspf_filter_checks #(.POS_W(POS_W)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .wordReady(wordReady),
  .busy     (busy),
  .done     (done),
  .accept   (accept),
  .errCode  (errCode),
  .errOffset(errOffset)
);

// File: tb/test_cspf_filter.sv
`timescale 1ns/1ps
module test_cspf_filter;
  localparam int POS_W = 16;
  localparam logic [31:0] ENDW = 32'h0500_0000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             isMaster = 1'b0;
  logic [POS_W-1:0] bufLen = '0;
  logic             wordValid;
  logic [31:0]      wordData;
  logic             wordReady;
  logic             cfgRuleWe = 1'b0, cfgWlWe = 1'b0;
  logic [3:0]       cfgIdx = '0;
  logic             cfgValid = 1'b0;
  logic [7:0]       cfgOp = '0;
  logic [1:0]       cfgCat = '0;
  logic [7:0]       cfgLen = '0;
  logic             cfgChkEn = 1'b0;
  logic [7:0]       cfgChkIdx = '0;
  logic [31:0]      cfgMask = '0, cfgValue = '0, cfgWlAddr = '0;
  logic             busy, done, accept;
  logic [2:0]       errCode;
  logic [POS_W-1:0] errOffset;

  logic [31:0] mem [0:15];
  int          ptr = 0;
  logic        rewind = 1'b0;
  logic        feedOn = 1'b0;
  logic        gapOn = 1'b0;
  logic        phase = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  assign wordData  = mem[ptr[3:0]];
  assign wordValid = feedOn && !(gapOn && phase);

  always @(posedge clk) begin
    phase <= ~phase;
    if (rewind) ptr <= 0;
    else if (wordValid && wordReady) ptr <= ptr + 1;
  end

  cspf_filter #(.POS_W(POS_W)) i_cspf_filter (
    .clk(clk), .rstN(rstN), .start(start), .isMaster(isMaster), .bufLen(bufLen),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .cfgRuleWe(cfgRuleWe), .cfgWlWe(cfgWlWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgOp(cfgOp), .cfgCat(cfgCat), .cfgLen(cfgLen), .cfgChkEn(cfgChkEn),
    .cfgChkIdx(cfgChkIdx), .cfgMask(cfgMask), .cfgValue(cfgValue), .cfgWlAddr(cfgWlAddr),
    .busy(busy), .done(done), .accept(accept), .errCode(errCode), .errOffset(errOffset)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic putRule(input int idx, input bit vld, input logic [7:0] op,
                         input logic [1:0] cat, input logic [7:0] len, input bit chk,
                         input logic [7:0] chkIdx, input logic [31:0] mask,
                         input logic [31:0] value);
    @(negedge clk);
    cfgIdx = 4'(idx); cfgValid = vld; cfgOp = op; cfgCat = cat; cfgLen = len;
    cfgChkEn = chk; cfgChkIdx = chkIdx; cfgMask = mask; cfgValue = value;
    cfgRuleWe = 1'b1;
    @(negedge clk);
    cfgRuleWe = 1'b0;
  endtask

  task automatic putWl(input int idx, input logic [31:0] addr);
    @(negedge clk);
    cfgIdx = 4'(idx); cfgValid = 1'b1; cfgWlAddr = addr; cfgWlWe = 1'b1;
    @(negedge clk);
    cfgWlWe = 1'b0;
  endtask

  task automatic kick(input int len, input bit master);
    @(negedge clk);
    bufLen = POS_W'(len); isMaster = master;
    start = 1'b1; rewind = 1'b1;
    @(negedge clk);
    start = 1'b0; rewind = 1'b0;
  endtask

  task automatic awaitVerdict(input string req, input bit expAcc, input int expCode,
                              input int expOff);
    int n = 0;
    feedOn = 1'b1;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    feedOn = 1'b0;
    check(done == 1'b1, req, "done", done, 1);
    check(accept == expAcc, req, "accept", accept, expAcc);
    check(errCode == 3'(expCode), req, "errCode", errCode, expCode);
    check(errOffset == POS_W'(expOff), req, "errOffset", errOffset, expOff);
  endtask

  task automatic runCase(input string req, input int len, input bit master,
                         input bit expAcc, input int expCode, input int expOff);
    kick(len, master);
    awaitVerdict(req, expAcc, expCode, expOff);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
  endtask

  // R12: reset state
  task automatic testReset();
    check(busy == 0 && done == 0, "R12", "busy/done after reset", {busy, done}, 0);
    check(wordReady == 0, "R12", "wordReady after reset", wordReady, 0);
    check(accept == 0 && errCode == 0, "R12", "verdict after reset", {accept, errCode}, 0);
  endtask

  // R1: class lengths, payload looking like forbidden headers
  task automatic testLength();
    clearMem();
    mem[0] = 32'h0000_0000; mem[1] = 32'h4000_0001;
    mem[2] = 32'h1100_0000; mem[3] = 32'h1200_0000; mem[4] = ENDW;
    runCase("R1", 5, 0, 1, 0, 4);
  endtask

  // R3 deny at header offset, then R9 hold and no consumption
  task automatic testDenyHold();
    clearMem();
    mem[1] = 32'h1100_0000; mem[2] = ENDW;
    runCase("R3", 4, 1, 0, 1, 1);
    repeat (5) @(negedge clk);
    check(done == 1 && errCode == 3'd1 && errOffset == 1, "R9", "verdict held",
          {done, errCode}, {1'b1, 3'd1});
    check(wordReady == 0, "R9", "wordReady after verdict", wordReady, 0);
    check(ptr == 2, "R9", "words consumed", ptr, 2);
  endtask

  // R4 master-only
  task automatic testMaster();
    clearMem();
    mem[0] = 32'h1200_0000; mem[1] = ENDW;
    runCase("R4", 4, 0, 0, 2, 0);
    runCase("R4", 4, 1, 1, 0, 1);
  endtask

  // R5 register whitelist on odd slots only, master makes no difference
  task automatic testRegs();
    clearMem();
    mem[0] = 32'h2200_0003; mem[1] = 32'h0000_2358; mem[2] = 32'h0000_9999;
    mem[3] = 32'h0000_7004; mem[4] = 32'h1100_0000; mem[5] = ENDW;
    runCase("R5", 8, 0, 1, 0, 5);
    mem[1] = 32'h0000_2100; mem[3] = 32'h0000_3000;
    runCase("R5", 8, 1, 0, 3, 3);
    runCase("R5", 8, 0, 0, 3, 3);
  endtask

  // R11 gapped valid gives the same verdict
  task automatic testGaps();
    clearMem();
    mem[0] = 32'h2200_0003; mem[1] = 32'h0000_2358; mem[2] = 32'h0000_9999;
    mem[3] = 32'h0000_7004; mem[4] = 32'h1100_0000; mem[5] = ENDW;
    gapOn = 1'b1;
    runCase("R11", 8, 0, 1, 0, 5);
    check(ptr == 6, "R11", "words consumed with gaps", ptr, 6);
    gapOn = 1'b0;
  endtask

  // R2 skip entry with explicit length
  task automatic testSkip();
    clearMem();
    mem[0] = 32'h0A00_0000; mem[1] = 32'h1100_0000; mem[2] = 32'h1100_0000; mem[3] = ENDW;
    runCase("R2", 6, 0, 1, 0, 3);
  endtask

  // R6 mask checks on header and operand word
  task automatic testMask();
    clearMem();
    mem[0] = 32'h2640_0001;
    runCase("R6", 6, 1, 0, 4, 0);
    mem[0] = 32'h2600_0001; mem[1] = 32'h1100_0000; mem[3] = ENDW;
    runCase("R6", 6, 1, 1, 0, 3);
    clearMem();
    mem[0] = 32'h7A00_0000; mem[1] = 32'h0000_0004;
    runCase("R6", 6, 0, 0, 4, 1);
    mem[1] = 32'hFFFF_FFFB; mem[2] = ENDW;
    runCase("R7", 6, 0, 1, 0, 2);
  endtask

  // R8 overrun cases
  task automatic testOverrun();
    clearMem();
    runCase("R8", 3, 0, 0, 5, 3);
    mem[0] = 32'h4000_0005;
    runCase("R8", 2, 0, 0, 5, 2);
    runCase("R8", 0, 0, 0, 5, 0);
  endtask

  // R10 table write during a scan is dropped, at idle it lands
  task automatic testBusyWrite();
    clearMem();
    mem[1] = ENDW;
    kick(4, 0);
    check(busy == 1, "R10", "busy while stalled", busy, 1);
    putRule(6, 1, 8'h00, 2'd1, 8'd0, 0, 8'd0, 32'h0, 32'h0);
    awaitVerdict("R10", 1, 0, 1);
    putRule(6, 1, 8'h00, 2'd1, 8'd0, 0, 8'd0, 32'h0, 32'h0);
    runCase("R10", 4, 0, 0, 1, 0);
    putRule(6, 0, 8'h00, 2'd0, 8'd0, 0, 8'd0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    putRule(0, 1, 8'h11, 2'd1, 8'd0, 0, 8'd0, 32'h0, 32'h0);
    putRule(1, 1, 8'h12, 2'd2, 8'd0, 0, 8'd0, 32'h0, 32'h0);
    putRule(2, 1, 8'h22, 2'd3, 8'd0, 0, 8'd0, 32'h0, 32'h0);
    putRule(3, 1, 8'h0A, 2'd0, 8'd3, 0, 8'd0, 32'h0, 32'h0);
    putRule(4, 1, 8'h26, 2'd0, 8'd0, 1, 8'd0, 32'h0040_0000, 32'h0);
    putRule(5, 1, 8'h7A, 2'd0, 8'd0, 1, 8'd1, 32'h0000_0004, 32'h0);
    putWl(0, 32'h0000_2358);
    putWl(1, 32'h0000_2100);
    putWl(2, 32'h0000_7004);
    testLength();
    testDenyHold();
    testMaster();
    testRegs();
    testGaps();
    testSkip();
    testMask();
    testOverrun();
    testBusyWrite();
    finish();
  end
endmodule